// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Interrupts

This block controls one bank of up to 32 general-purpose pins through a small 32-bit register bus. Software drives pin levels and turns output drivers on and off through plain registers or through write-one set and clear aliases, which change single bits without a read-modify-write. Every input pin passes through a two-flop synchronizer. A per-pin polarity bit then adjusts it before it can be read back or used for interrupt detection.

Each pin can raise the combined interrupt line in one of two ways. In edge mode, a rising edge on the adjusted input latches a sticky cause bit, and the edge mask lets that bit through. In level mode, the level mask lets the adjusted input level through directly. Setting the polarity bit turns rising-edge and active-high detection into falling-edge and active-low detection. A cause bit is cleared by writing a word that has a zero in that bit position. A blink-enable register is stored and read back but has no effect on the pins.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the direction register reads all ones (every pin is an input, `padOe` low) and the output data register reads zero. Polarity, blink enable, cause, edge mask and level mask also read zero, and `irq` is low.
- R2: `padOut` follows the output data register. `padOe` bit n is high only when direction bit n is 0; a direction bit of 1 means the pin is an input.
- R3: Four write-only aliases sit at word addresses 10, 11, 12 and 13 (byte offsets 0x28, 0x2C, 0x30, 0x34). Writing word 10 sets direction bits and word 11 clears them. Writing word 12 sets output data bits and word 13 clears them. Only bits written as 1 change; bits written as 0 are left as they were. Reading these aliases returns zero.
- R4: Six plain read/write registers take a full-word write: output data at word 0, direction at word 1, blink enable at word 2, polarity at word 3, edge mask at word 6 and level mask at word 7. A read returns the stored value, and bits at or above NUM_PINS read as zero.
- R5: Word 4 reads the synchronized input XOR the polarity register. A pad change first becomes visible on the third clock edge after it. Writes to word 4 are ignored.
- R6: A 0-to-1 transition of the polarity-adjusted input sets the pin's cause bit (word 5). With polarity bit 1, a falling pad edge sets the bit instead.
- R7: Writing word 5 clears every cause bit written as 0 and keeps every bit written as 1. If an edge event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R8: `irq` is a register loaded each cycle with the OR over all pins of (cause AND edge mask) OR (adjusted input AND level mask). A level interrupt therefore stays asserted for as long as its condition holds.
- R9: A read (`sel` high, `we` low) loads `rdata` on that clock edge, and `rdata` holds its value until the next read. Word addresses 8, 9, 14 and 15 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | Write when high, read when low |
| addr | input | 4 | Word address (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after the read |
| padIn | input | NUM_PINS | Asynchronous pin inputs |
| padOut | output | NUM_PINS | Pin output values |
| padOe | output | NUM_PINS | Pin output-driver enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the bus carries at most one access per cycle and that the pad inputs are defined (not X) from reset onward. The stimulus meets both conditions: a single bus access is driven on each falling edge, and every input is initialised before reset is released. The cause and mask assertions also rely on the edge event seen in a cycle coming from the same synchronized sample the bench model uses. For that reason, pad changes are made only on falling edges. Some directed sequences place an edge event in the same cycle as a clearing write. A random phase then mixes accesses to all sixteen word addresses with pad toggles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_OUT    = 4'd0,
    RA_DIR    = 4'd1,
    RA_BLINK  = 4'd2,
    RA_POL    = 4'd3,
    RA_IN     = 4'd4,
    RA_CAUSE  = 4'd5,
    RA_EMASK  = 4'd6,
    RA_LMASK  = 4'd7,
    RA_DIRSET = 4'd10,
    RA_DIRCLR = 4'd11,
    RA_OUTSET = 4'd12,
    RA_OUTCLR = 4'd13
  } regAddr_e;

  typedef struct packed {
    logic              wrOut;
    logic              wrDir;
    logic              wrBlink;
    logic              wrPol;
    logic              wrCause;
    logic              wrEmask;
    logic              wrLmask;
    logic              setDir;
    logic              clrDir;
    logic              setOut;
    logic              clrOut;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } ctlStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        strb
);
  logic isWrite;
  assign isWrite = sel & we;

  always_comb begin
    strb        = '0;
    strb.rdEn   = sel & ~we;
    strb.rdAddr = addr;
    if (isWrite) begin
      case (addr)
        RA_OUT:    strb.wrOut   = 1'b1;
        RA_DIR:    strb.wrDir   = 1'b1;
        RA_BLINK:  strb.wrBlink = 1'b1;
        RA_POL:    strb.wrPol   = 1'b1;
        RA_CAUSE:  strb.wrCause = 1'b1;
        RA_EMASK:  strb.wrEmask = 1'b1;
        RA_LMASK:  strb.wrLmask = 1'b1;
        RA_DIRSET: strb.setDir  = 1'b1;
        RA_DIRCLR: strb.clrDir  = 1'b1;
        RA_OUTSET: strb.setOut  = 1'b1;
        RA_OUTCLR: strb.clrOut  = 1'b1;
        default:   ;
      endcase
    end
  end

  // R9: one access per cycle, so at most one strobe fires
  p_single_access_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrOut, strb.wrDir, strb.wrBlink, strb.wrPol, strb.wrCause,
              strb.wrEmask, strb.wrLmask, strb.setDir, strb.clrDir,
              strb.setOut, strb.clrOut, strb.rdEn}));
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic [BUS_W-1:0]    wdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [BUS_W-1:0]    rdata,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irq
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;
  typedef logic [NUM_PINS-1:0] pinVec_t;

  pinVec_t outReg, dirReg, blinkReg, polReg, causeReg, emaskReg, lmaskReg;
  pinVec_t adjIn, prevAdj, riseVec, causeNext, wrBits;
  pinVec_t syncPipe [SYNC_STAGES];
  logic [BUS_W-1:0] readVal;

  assign wrBits = wdata[NUM_PINS-1:0];

  // input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
    end else begin
      syncPipe[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign adjIn = syncPipe[LAST_STAGE] ^ polReg;

  // per-pin edge detection and cause update
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign riseVec[p]   = adjIn[p] & ~prevAdj[p];
    assign causeNext[p] = (causeReg[p] & (~strb.wrCause | wrBits[p])) | riseVec[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      dirReg   <= '1;
      blinkReg <= '0;
      polReg   <= '0;
      emaskReg <= '0;
      lmaskReg <= '0;
      causeReg <= '0;
      prevAdj  <= '0;
      irq      <= 1'b0;
    end else begin
      if (strb.wrOut)       outReg <= wrBits;
      else if (strb.setOut) outReg <= outReg | wrBits;
      else if (strb.clrOut) outReg <= outReg & ~wrBits;

      if (strb.wrDir)       dirReg <= wrBits;
      else if (strb.setDir) dirReg <= dirReg | wrBits;
      else if (strb.clrDir) dirReg <= dirReg & ~wrBits;

      if (strb.wrBlink) blinkReg <= wrBits;
      if (strb.wrPol)   polReg   <= wrBits;
      if (strb.wrEmask) emaskReg <= wrBits;
      if (strb.wrLmask) lmaskReg <= wrBits;

      causeReg <= causeNext;
      prevAdj  <= adjIn;
      irq      <= |((causeReg & emaskReg) | (adjIn & lmaskReg));
    end
  end

  always_comb begin
    case (strb.rdAddr)
      RA_OUT:   readVal = BUS_W'(outReg);
      RA_DIR:   readVal = BUS_W'(dirReg);
      RA_BLINK: readVal = BUS_W'(blinkReg);
      RA_POL:   readVal = BUS_W'(polReg);
      RA_IN:    readVal = BUS_W'(adjIn);
      RA_CAUSE: readVal = BUS_W'(causeReg);
      RA_EMASK: readVal = BUS_W'(emaskReg);
      RA_LMASK: readVal = BUS_W'(lmaskReg);
      default:  readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (strb.rdEn) rdata <= readVal;
  end

  assign padOut = outReg;
  assign padOe  = ~dirReg;

  // R3: clear-alias bits enable their output drivers on the next cycle
  p_dir_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrDir |=> ((padOe & $past(wrBits)) == $past(wrBits)));

  // R3: set-alias bits drive high on the next cycle
  p_out_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setOut |=> ((padOut & $past(wrBits)) == $past(wrBits)));

  // R7: cause bits never fall without a write to the cause register
  p_cause_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCause |=> ((causeReg & $past(causeReg)) == $past(causeReg)));

  // R7: after a clearing write only kept bits or fresh edges remain
  p_cause_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCause |=> ((causeReg & ~$past(wrBits) & ~$past(riseVec)) == '0));

  // R8: no enabled source means no interrupt on the next cycle
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (((causeReg & emaskReg) | (adjIn & lmaskReg)) == '0) |=> !irq);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sel,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irq
);
  ctlStrobe_t strb;

  gpio_irq_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .sel  (sel),
    .we   (we),
    .addr (addr),
    .strb (strb)
  );

  gpio_irq_datapath #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (wdata),
    .padIn  (padIn),
    .rdata  (rdata),
    .padOut (padOut),
    .padOe  (padOe),
    .irq    (irq)
  );
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam int PINS = 32;
  localparam real HALF = 10.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [PINS-1:0] padIn = '0;
  logic [31:0] rdata;
  logic [PINS-1:0] padOut, padOe;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit cmpOn = 1'b0;

  always #(HALF) clk = ~clk;

  gpio_irq_bank #(.NUM_PINS(PINS)) u0 (
    .clk(clk), .rstN(rstN), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .padIn(padIn), .padOut(padOut), .padOe(padOe), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] mOut = 0, mDir = '1, mBlink = 0, mPol = 0, mCause = 0;
  logic [31:0] mEm = 0, mLm = 0, mS1 = 0, mS2 = 0, mPrev = 0, mRd = 0;
  logic mIrq = 1'b0;

  always @(posedge clk) begin
    logic [31:0] adj, rise, nc;
    if (!rstN) begin
      mOut = 0; mDir = '1; mBlink = 0; mPol = 0; mCause = 0; mEm = 0; mLm = 0;
      mS1 = 0; mS2 = 0; mPrev = 0; mRd = 0; mIrq = 0;
    end else begin
      adj  = mS2 ^ mPol;
      rise = adj & ~mPrev;
      mIrq = ((mCause & mEm) | (adj & mLm)) != 0;
      nc = mCause;
      if (sel && !we) begin
        case (addr)
          0: mRd = mOut;   1: mRd = mDir;   2: mRd = mBlink; 3: mRd = mPol;
          4: mRd = adj;    5: mRd = mCause; 6: mRd = mEm;    7: mRd = mLm;
          default: mRd = 0;
        endcase
      end
      if (sel && we) begin
        case (addr)
          0: mOut = wdata;   1: mDir = wdata;  2: mBlink = wdata; 3: mPol = wdata;
          5: nc = mCause & wdata;
          6: mEm = wdata;    7: mLm = wdata;
          10: mDir = mDir | wdata;  11: mDir = mDir & ~wdata;
          12: mOut = mOut | wdata;  13: mOut = mOut & ~wdata;
          default: ;
        endcase
      end
      mCause = nc | rise;
      mPrev = adj;
      mS2 = mS1;
      mS1 = padIn;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      chk("R2 padOut", padOut, mOut);
      chk("R2 padOe", padOe, ~mDir);
      chk("R8 irq", {31'b0, irq}, {31'b0, mIrq});
      chk("R9 rdata", rdata, mRd);
    end
  end

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [31:0] d);
    sel = 1; we = 0; addr = a;
    @(negedge clk);
    sel = 0;
    d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(4);
    rstN = 1;
    cmpOn = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 padOe", padOe, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    busRead(0, v);  chk("R1 out", v, 32'h0);
    busRead(1, v);  chk("R1 dir", v, 32'hFFFF_FFFF);
    busRead(2, v);  chk("R1 blink", v, 32'h0);
    busRead(3, v);  chk("R1 pol", v, 32'h0);
    busRead(5, v);  chk("R1 cause", v, 32'h0);
    busRead(6, v);  chk("R1 emask", v, 32'h0);
    busRead(7, v);  chk("R1 lmask", v, 32'h0);
    // R2 / R4 plain registers
    busWrite(0, 32'hA5A5_5A5A);
    busWrite(1, 32'hFFFF_0000);
    chk("R2 padOut", padOut, 32'hA5A5_5A5A);
    chk("R2 padOe", padOe, 32'h0000_FFFF);
    busRead(0, v);  chk("R4 out", v, 32'hA5A5_5A5A);
    busRead(1, v);  chk("R4 dir", v, 32'hFFFF_0000);
    busWrite(2, 32'h1234_5678);
    busRead(2, v);  chk("R4 blink", v, 32'h1234_5678);
    chk("R4 blink no pin effect", padOut, 32'hA5A5_5A5A);
    // R3 aliases
    busWrite(12, 32'h0000_000F);
    busWrite(13, 32'hA000_0000);
    chk("R3 out set/clr", padOut, 32'h05A5_5A5F);
    busWrite(10, 32'h0000_00F0);
    busWrite(11, 32'h00FF_0000);
    busRead(1, v);  chk("R3 dir set/clr", v, 32'hFF00_00F0);
    busRead(12, v); chk("R3 alias read", v, 32'h0);
    busRead(11, v); chk("R3 alias read", v, 32'h0);
    // R9 unmapped
    busRead(8, v);  chk("R9 unmapped", v, 32'h0);
    busRead(15, v); chk("R9 unmapped", v, 32'h0);
    // R5 / R6 input and rising edge
    padIn[0] = 1;
    idle(4);
    busRead(4, v);  chk("R5 input", v, 32'h1);
    busWrite(4, 32'hFFFF_FFFF);
    busRead(4, v);  chk("R5 write ignored", v, 32'h1);
    busRead(5, v);  chk("R6 rise", v, 32'h1);
    // R6 polarity: falling pad edge
    busWrite(3, 32'h2);
    idle(1);
    busWrite(5, ~32'h2);
    busRead(5, v);  chk("R7 clear one bit", v, 32'h1);
    padIn[1] = 1; idle(4);
    padIn[1] = 0; idle(4);
    busRead(5, v);  chk("R6 falling edge", v, 32'h3);
    busRead(4, v);  chk("R5 inverted input", v, 32'h3);
    // R7 event wins over clear in the same cycle
    padIn[2] = 1;
    idle(2);
    busWrite(5, 32'h0);
    busRead(5, v);  chk("R7 event wins", v, 32'h4);
    // R8 edge interrupt
    busWrite(6, 32'h4);
    idle(2);
    chk("R8 edge irq", {31'b0, irq}, 32'h1);
    busWrite(5, 32'h0);
    idle(2);
    chk("R8 edge irq cleared", {31'b0, irq}, 32'h0);
    // R8 level interrupt
    busWrite(7, 32'h8);
    padIn[3] = 1;
    idle(4);
    chk("R8 level irq", {31'b0, irq}, 32'h1);
    idle(10);
    chk("R8 level held", {31'b0, irq}, 32'h1);
    padIn[3] = 0;
    idle(4);
    chk("R8 level drop", {31'b0, irq}, 32'h0);
    // random phase, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) padIn = padIn ^ (32'h1 << $urandom_range(0, 31));
      if (op == 0) begin
        idle(1);
      end else if (op == 1) begin
        busWrite(4'($urandom_range(0, 15)), $urandom);
      end else begin
        busRead(4'($urandom_range(0, 15)), v);
      end
    end
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule